// File: doc/BRIEF.md
# Serial Burst Read Port

This block is the slave side of a four-wire serial link that streams data out of an on-chip storage array. A master lowers the chip select, clocks in a one-byte command and a start address, and then keeps clocking to receive consecutive locations until it raises chip select again. Bits move most significant first in both directions. Input data is taken on the rising serial clock edge and output data changes after the falling edge, which is SPI mode 0.

A static input selects one of two burst styles. The wide style takes a 16-bit address and returns 16-bit words, and it wraps around a 512-word array. The narrow style takes an 8-bit address and returns bytes. It stops at location 255 and releases the output line once that last byte has been sent. A busy input blocks reads while the array is being programmed. The array sits behind a synchronous read port with one cycle of latency.

The serial pins are oversampled in the system clock domain. The output line is delivered as a data bit `sdo` and an enable `sdo_oe`, and the tri-state pad sits outside the block.

Top module: `spi_rd_slave`

## Requirements
- R1: While chip select is high, `sdo_oe` is 0. Raising chip select ends a transaction at any bit, and the next low period starts again with a command byte.
- R2: `sdi` is taken on SCK rising edges, most significant bit first. `sdo` changes only after SCK falling edges, so it is stable across each rising edge. `sdo_oe` stays 0 during the command and address bits.
- R3: Only the command value 0x03 starts a read. Any other value keeps `sdo_oe` at 0 and causes the rest of the transaction to be ignored.
- R4: If `busy` is 1 when the eighth command bit arrives, the read is refused. No array read is issued, and `sdo_oe` stays 0 until chip select rises.
- R5: With `ext_mode`=1, 16 address bits follow the command. Only the low 9 bits select the location, and the upper 7 are discarded.
- R6: With `ext_mode`=1, data comes out as back-to-back 16-bit words from consecutive locations. Location 511 is followed by location 0.
- R7: With `ext_mode`=0, 8 address bits follow the command. Data comes out as back-to-back bytes, each byte being bits [7:0] of the array word at consecutive locations.
- R8: With `ext_mode`=0, the location never goes past 255. After the eighth bit of location 255 has been sent, `sdo_oe` returns to 0 for the rest of the transaction, and no read above 255 is issued.
- R9: Each array read is a single-cycle `mem_rd_en` pulse, and `mem_rdata` is taken one cycle later. The next location is requested while the last bit of the current one is being sent, so there is no gap between words.
- R10: After reset, `sdo_oe` and `mem_rd_en` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | Burst style: 1 = 16-bit address and words, 0 = 8-bit address and bytes |
| busy | input | 1 | Array is being programmed; reads are refused |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Serial data to the master |
| sdo_oe | output | 1 | Output enable for the external tri-state pad |
| mem_rd_en | output | 1 | Array read strobe |
| mem_addr | output | 9 | Array read location |
| mem_rdata | input | 16 | Array read data, valid one cycle after the strobe |

## Verification
The assertions assume that `ext_mode` does not change during a transaction. They also assume that SCK and chip select change slowly compared with `clk`, so that every serial edge is seen after synchronisation and the array read completes before the next falling edge. The stimulus sets the mode only while chip select is high. It holds each serial clock phase for eight system clocks, and it follows the SCK-low idle level of mode 0. Busy is changed only between transactions, so it is stable when the command byte completes.

// File: rtl/spird_pkg.sv
package spird_pkg;
   typedef enum logic [2:0] {
      PH_CMD,
      PH_ADDR,
      PH_DATA,
      PH_SKIP,
      PH_END
   } rd_phase_e;
endpackage

// File: rtl/spird_sync.sv
module spird_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int CHAIN_W = W * STAGES;

   logic [CHAIN_W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[CHAIN_W-W-1:0], d};
   end

   assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/spird_edge.sv
module spird_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise,
   output logic fall
);
   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

   assign rise = lvl & ~lvl_q;
   assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/spird_txshift.sv
module spird_txshift #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              load,
   input  logic              shift,
   input  logic [WORD_W-1:0] load_val,
   output logic              msb
);
   logic [WORD_W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sr <= '0;
      else if (clear) sr <= '0;
      else if (load)  sr <= load_val;
      else if (shift) sr <= {sr[WORD_W-2:0], 1'b0};
   end

   assign msb = sr[WORD_W-1];
endmodule

// File: rtl/spird_ctrl.sv
module spird_ctrl
   import spird_pkg::*;
#(
   parameter int         ARR_AW      = 9,
   parameter int         WORD_W      = 16,
   parameter int         BYTE_W      = 8,
   parameter int         EXT_ADDR_W  = 16,
   parameter int         BASE_ADDR_W = 8,
   parameter int         BASE_LAST   = 255,
   parameter logic [7:0] RD_OPCODE   = 8'h03
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_mode,
   input  logic              busy,
   input  logic              cs_hi,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic              sdi_s,
   output rd_phase_e         phase,
   output logic              tx_load,
   output logic              tx_shift,
   output logic [WORD_W-1:0] tx_val,
   output logic              sdo_oe,
   output logic              mem_rd_en,
   output logic [ARR_AW-1:0] mem_addr,
   input  logic [WORD_W-1:0] mem_rdata
);
   localparam int OP_W   = 8;
   localparam int MAXLEN = (EXT_ADDR_W > WORD_W) ? EXT_ADDR_W : WORD_W;
   localparam int CNT_W  = $clog2(MAXLEN) + 1;
   localparam int PAD_W  = WORD_W - BYTE_W;

   typedef logic [ARR_AW-1:0] ptr_t;
   typedef logic [CNT_W-1:0]  cnt_t;

   localparam cnt_t OP_LAST   = cnt_t'(OP_W - 1);
   localparam cnt_t EXT_ALAST = cnt_t'(EXT_ADDR_W - 1);
   localparam cnt_t BAS_ALAST = cnt_t'(BASE_ADDR_W - 1);
   localparam cnt_t EXT_WLAST = cnt_t'(WORD_W - 1);
   localparam cnt_t BAS_WLAST = cnt_t'(BYTE_W - 1);
   localparam ptr_t PTR_STOP  = ptr_t'(BASE_LAST);

   cnt_t                  bit_cnt;
   logic [EXT_ADDR_W-1:0] in_sr;
   logic [EXT_ADDR_W-1:0] in_next;
   ptr_t                  ptr;
   ptr_t                  ptr_inc;
   ptr_t                  start_ptr;
   logic                  rd_pend;
   logic [WORD_W-1:0]     word_buf;
   logic                  last_hit;
   cnt_t                  addr_last;
   cnt_t                  word_last;
   logic                  at_stop;
   logic                  data_fall;

   assign in_next   = {in_sr[EXT_ADDR_W-2:0], sdi_s};
   assign addr_last = ext_mode ? EXT_ALAST : BAS_ALAST;
   assign word_last = ext_mode ? EXT_WLAST : BAS_WLAST;
   assign at_stop   = !ext_mode && (ptr == PTR_STOP);
   assign ptr_inc   = ptr + 1'b1;
   assign start_ptr = ext_mode ? in_next[ARR_AW-1:0]
                               : ptr_t'(in_next[BASE_ADDR_W-1:0]);
   assign data_fall = !cs_hi && (phase == PH_DATA) && sck_fall && !last_hit;

   assign tx_load  = data_fall && (bit_cnt == '0);
   assign tx_shift = data_fall && (bit_cnt != '0);
   assign tx_val   = word_buf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_CMD;
         bit_cnt   <= '0;
         in_sr     <= '0;
         ptr       <= '0;
         rd_pend   <= 1'b0;
         word_buf  <= '0;
         last_hit  <= 1'b0;
         sdo_oe    <= 1'b0;
         mem_rd_en <= 1'b0;
         mem_addr  <= '0;
      end else begin
         mem_rd_en <= 1'b0;
         rd_pend   <= mem_rd_en;
         if (rd_pend) begin
            word_buf <= ext_mode ? mem_rdata
                                 : {mem_rdata[BYTE_W-1:0], {PAD_W{1'b0}}};
         end
         if (cs_hi) begin
            phase    <= PH_CMD;
            bit_cnt  <= '0;
            last_hit <= 1'b0;
            sdo_oe   <= 1'b0;
         end else begin
            unique case (phase)
               PH_CMD: begin
                  if (sck_rise) begin
                     in_sr <= in_next;
                     if (bit_cnt == OP_LAST) begin
                        bit_cnt <= '0;
                        if ((in_next[OP_W-1:0] == RD_OPCODE) && !busy)
                           phase <= PH_ADDR;
                        else
                           phase <= PH_SKIP;
                     end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                     end
                  end
               end
               PH_ADDR: begin
                  if (sck_rise) begin
                     in_sr <= in_next;
                     if (bit_cnt == addr_last) begin
                        bit_cnt   <= '0;
                        ptr       <= start_ptr;
                        mem_addr  <= start_ptr;
                        mem_rd_en <= 1'b1;
                        phase     <= PH_DATA;
                     end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                     end
                  end
               end
               PH_DATA: begin
                  if (sck_fall) begin
                     if (last_hit) begin
                        sdo_oe <= 1'b0;
                        phase  <= PH_END;
                     end else if (bit_cnt == '0) begin
                        sdo_oe  <= 1'b1;
                        bit_cnt <= bit_cnt + 1'b1;
                     end else if (bit_cnt == word_last) begin
                        bit_cnt <= '0;
                        if (at_stop) begin
                           last_hit <= 1'b1;
                        end else begin
                           ptr       <= ptr_inc;
                           mem_addr  <= ptr_inc;
                           mem_rd_en <= 1'b1;
                        end
                     end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                     end
                  end
               end
               PH_SKIP, PH_END: begin
                  bit_cnt <= '0;
               end
               default: phase <= PH_SKIP;
            endcase
         end
      end
   end
endmodule

// File: rtl/spi_rd_slave.sv
module spi_rd_slave #(
   parameter int         ARR_AW      = 9,
   parameter int         WORD_W      = 16,
   parameter int         BYTE_W      = 8,
   parameter int         EXT_ADDR_W  = 16,
   parameter int         BASE_ADDR_W = 8,
   parameter int         BASE_LAST   = 255,
   parameter logic [7:0] RD_OPCODE   = 8'h03,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_mode,
   input  logic              busy,
   input  logic              cs_n,
   input  logic              sck,
   input  logic              sdi,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              mem_rd_en,
   output logic [ARR_AW-1:0] mem_addr,
   input  logic [WORD_W-1:0] mem_rdata
);
   import spird_pkg::*;

   localparam int PIN_W = 3;

   generate
      if (ARR_AW > EXT_ADDR_W) begin : g_bad_aw
         $error("ARR_AW must not exceed EXT_ADDR_W");
      end
      if (BASE_ADDR_W > ARR_AW) begin : g_bad_base_aw
         $error("BASE_ADDR_W must not exceed ARR_AW");
      end
      if (BASE_LAST >= (1 << BASE_ADDR_W)) begin : g_bad_last
         $error("BASE_LAST must fit in BASE_ADDR_W bits");
      end
      if (BYTE_W >= WORD_W) begin : g_bad_byte
         $error("BYTE_W must be narrower than WORD_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [PIN_W-1:0]  pins_s;
   logic              cs_hi;
   logic              sck_s;
   logic              sdi_s;
   logic              sck_rise;
   logic              sck_fall;
   rd_phase_e         phase;
   logic              tx_load;
   logic              tx_shift;
   logic [WORD_W-1:0] tx_val;

   spird_sync #(
      .W       (PIN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sck, sdi}),
      .q     (pins_s)
   );

   assign cs_hi = pins_s[2];
   assign sck_s = pins_s[1];
   assign sdi_s = pins_s[0];

   spird_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (sck_s),
      .rise  (sck_rise),
      .fall  (sck_fall)
   );

   spird_ctrl #(
      .ARR_AW      (ARR_AW),
      .WORD_W      (WORD_W),
      .BYTE_W      (BYTE_W),
      .EXT_ADDR_W  (EXT_ADDR_W),
      .BASE_ADDR_W (BASE_ADDR_W),
      .BASE_LAST   (BASE_LAST),
      .RD_OPCODE   (RD_OPCODE)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_mode  (ext_mode),
      .busy      (busy),
      .cs_hi     (cs_hi),
      .sck_rise  (sck_rise),
      .sck_fall  (sck_fall),
      .sdi_s     (sdi_s),
      .phase     (phase),
      .tx_load   (tx_load),
      .tx_shift  (tx_shift),
      .tx_val    (tx_val),
      .sdo_oe    (sdo_oe),
      .mem_rd_en (mem_rd_en),
      .mem_addr  (mem_addr),
      .mem_rdata (mem_rdata)
   );

   spird_txshift #(
      .WORD_W (WORD_W)
   ) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (cs_hi),
      .load     (tx_load),
      .shift    (tx_shift),
      .load_val (tx_val),
      .msb      (sdo)
   );
endmodule

// File: rtl/spird_chk.sv
module spird_chk
   import spird_pkg::*;
#(
   parameter int ARR_AW    = 9,
   parameter int BASE_LAST = 255
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ext_mode,
   input logic              cs_hi,
   input logic              sdo_oe,
   input logic              mem_rd_en,
   input logic [ARR_AW-1:0] mem_addr,
   input rd_phase_e         phase
);
   logic [ARR_AW-1:0] last_addr;
   logic [ARR_AW-1:0] next_addr;
   logic              cont;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cont      <= 1'b0;
         last_addr <= '0;
      end else if (cs_hi) begin
         cont <= 1'b0;
      end else if (mem_rd_en) begin
         cont      <= 1'b1;
         last_addr <= mem_addr;
      end
   end

   assign next_addr = last_addr + 1'b1;

   a_r1_release_on_cs : assert property (@(posedge clk) disable iff (!rst_n)
      cs_hi |=> !sdo_oe);

   a_r2_drive_only_in_data : assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe |-> (phase == PH_DATA));

   a_r9_single_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en);

   a_r6_ext_sequential : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && cont && ext_mode) |-> (mem_addr == next_addr));

   a_r8_base_ceiling : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && !ext_mode) |-> (int'(mem_addr) <= BASE_LAST));

   a_r8_base_no_wrap : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && cont && !ext_mode) |->
         ((int'(last_addr) != BASE_LAST) && (mem_addr == next_addr)));
endmodule

bind spi_rd_slave spird_chk #(
   .ARR_AW    (ARR_AW),
   .BASE_LAST (BASE_LAST)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ext_mode  (ext_mode),
   .cs_hi     (cs_hi),
   .sdo_oe    (sdo_oe),
   .mem_rd_en (mem_rd_en),
   .mem_addr  (mem_addr),
   .phase     (phase)
);

// File: tb/spi_rd_slave_tb.sv
`timescale 1ns/1ps
module spi_rd_slave_tb;
   localparam int HALF = 8;
   localparam int NVEC = 10;
   localparam int MAXW = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_mode = 1'b1;
   logic        busy = 1'b0;
   logic        cs_n = 1'b1;
   logic        sck = 1'b0;
   logic        sdi = 1'b0;
   logic        sdo;
   logic        sdo_oe;
   logic        mem_rd_en;
   logic [8:0]  mem_addr;
   logic [15:0] mem_rdata = '0;

   int n_chk = 0;
   int n_fail = 0;
   int rd_cnt = 0;
   int unstable = 0;
   bit hdr_oe;
   logic [15:0] rx_w   [0:MAXW-1];
   bit          rx_on  [0:MAXW-1];
   bit          rx_off [0:MAXW-1];

   // {tag, ext, busy, opcode, address, words}
   localparam logic [41:0] VEC [0:NVEC-1] = '{
      {8'd6, 1'b1, 1'b0, 8'h03, 16'h0010, 8'd3},
      {8'd5, 1'b1, 1'b0, 8'h03, 16'hFE05, 8'd2},
      {8'd6, 1'b1, 1'b0, 8'h03, 16'h01FE, 8'd4},
      {8'd7, 1'b0, 1'b0, 8'h03, 16'h0040, 8'd3},
      {8'd8, 1'b0, 1'b0, 8'h03, 16'h00FE, 8'd4},
      {8'd4, 1'b1, 1'b1, 8'h03, 16'h0000, 8'd2},
      {8'd3, 1'b0, 1'b0, 8'h5A, 16'h0011, 8'd2},
      {8'd4, 1'b0, 1'b1, 8'h03, 16'h0033, 8'd1},
      {8'd8, 1'b0, 1'b0, 8'h03, 16'h00FF, 8'd2},
      {8'd3, 1'b1, 1'b0, 8'h0B, 16'h0000, 8'd2}
   };

   always #2.5 clk = ~clk;

   spi_rd_slave u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_mode  (ext_mode),
      .busy      (busy),
      .cs_n      (cs_n),
      .sck       (sck),
      .sdi       (sdi),
      .sdo       (sdo),
      .sdo_oe    (sdo_oe),
      .mem_rd_en (mem_rd_en),
      .mem_addr  (mem_addr),
      .mem_rdata (mem_rdata)
   );

   function automatic logic [15:0] mem_f(input int a);
      return 16'(a * 263) ^ 16'hC35A;
   endfunction

   always @(posedge clk) begin
      if (mem_rd_en) begin
         mem_rdata <= mem_f(int'(mem_addr));
         rd_cnt    <= rd_cnt + 1;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic send_bit(input logic b, output logic so, output logic oe);
      sdi = b;
      repeat (HALF) @(negedge clk);
      so = sdo;
      oe = sdo_oe;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      if (sdo !== so) unstable++;
      sck = 1'b0;
   endtask

   task automatic run_txn(input bit ext, input bit bsy, input logic [7:0] op,
                          input logic [15:0] addr, input int nw, input int extra);
      logic so, oe;
      int alen, wl;
      alen = ext ? 16 : 8;
      wl   = ext ? 16 : 8;
      @(negedge clk);
      ext_mode = ext;
      busy = bsy;
      hdr_oe = 1'b0;
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 7; i >= 0; i--) begin
         send_bit(op[i], so, oe);
         hdr_oe |= oe;
      end
      for (int i = alen - 1; i >= 0; i--) begin
         send_bit(addr[i], so, oe);
         hdr_oe |= oe;
      end
      for (int k = 0; k < nw; k++) begin
         rx_w[k] = '0;
         rx_on[k] = 1'b1;
         rx_off[k] = 1'b1;
         for (int i = 0; i < wl; i++) begin
            send_bit(1'b0, so, oe);
            rx_w[k] = {rx_w[k][14:0], so};
            rx_on[k] &= oe;
            rx_off[k] &= !oe;
         end
      end
      for (int i = 0; i < extra; i++) send_bit(1'b0, so, oe);
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (2 * HALF) @(negedge clk);
      busy = 1'b0;
   endtask

   function automatic string tag_name(input int t);
      case (t)
         3: return "R3";
         4: return "R4";
         5: return "R5";
         6: return "R6";
         7: return "R7";
         default: return "R8";
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int rd_before;
      repeat (5) @(negedge clk);
      // R10: reset state
      check(sdo_oe == 1'b0, "R10", "sdo_oe in reset", 32'(sdo_oe), 0);
      check(mem_rd_en == 1'b0, "R10", "mem_rd_en in reset", 32'(mem_rd_en), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(sdo_oe == 1'b0, "R10", "sdo_oe after reset", 32'(sdo_oe), 0);

      for (int v = 0; v < NVEC; v++) begin
         logic [41:0] e;
         bit ext, bsy, live;
         logic [7:0] op;
         logic [15:0] ad;
         int nw, a;
         string rq;
         e = VEC[v];
         ext = e[33];
         bsy = e[32];
         op  = e[31:24];
         ad  = e[23:8];
         nw  = int'(e[7:0]);
         rq  = tag_name(int'(e[41:34]));
         rd_before = rd_cnt;
         unstable = 0;
         run_txn(ext, bsy, op, ad, nw, 0);
         // R2: released through command and address, stable across rises
         check(!hdr_oe, "R2", "sdo_oe during header", 32'(hdr_oe), 0);
         check(unstable == 0, "R2", "sdo moved across SCK rise", 32'(unstable), 0);
         for (int k = 0; k < nw; k++) begin
            if (ext) a = (int'(ad[8:0]) + k) % 512;
            else     a = int'(ad[7:0]) + k;
            live = (op == 8'h03) && !bsy && (ext || a <= 255);
            if (live) begin
               logic [15:0] exp;
               exp = ext ? mem_f(a) : {8'h00, mem_f(a)[7:0]};
               check(rx_on[k], rq, "sdo_oe during data", 32'(rx_on[k]), 1);
               check(rx_w[k] == exp, rq, "data word", 32'(rx_w[k]), 32'(exp));
            end else begin
               check(rx_off[k], (!ext && a > 255 && op == 8'h03 && !bsy) ? "R8" : rq,
                     "sdo_oe must stay 0", 32'(rx_off[k]), 1);
            end
         end
         if (bsy) check(rd_cnt == rd_before, "R4", "reads while busy",
                        32'(rd_cnt - rd_before), 0);
      end

      // R9: one read pulse per byte, no read beyond the last location
      rd_before = rd_cnt;
      run_txn(1'b0, 1'b0, 8'h03, 16'h0080, 3, 0);
      check(rd_cnt - rd_before == 4, "R9", "reads for 3 bytes (one prefetch)",
            32'(rd_cnt - rd_before), 4);
      rd_before = rd_cnt;
      run_txn(1'b0, 1'b0, 8'h03, 16'h00FF, 3, 0);
      check(rd_cnt - rd_before == 1, "R8", "reads at top of narrow range",
            32'(rd_cnt - rd_before), 1);

      // R1: abort mid-word, then a clean transaction
      run_txn(1'b1, 1'b0, 8'h03, 16'h0020, 0, 5);
      check(sdo_oe == 1'b0, "R1", "sdo_oe after abort", 32'(sdo_oe), 0);
      run_txn(1'b1, 1'b0, 8'h03, 16'h0030, 1, 0);
      check(rx_w[0] == mem_f(16'h30), "R1", "word after abort",
            32'(rx_w[0]), 32'(mem_f(16'h30)));

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule